// File: doc/BRIEF.md
# Serial Shift-and-Store Register with Cascade Taps

This block turns a serial bit stream into a parallel word. Bits arrive on a serial input and move one position through a chain of shift stages on every rising edge of the shift clock. A separate storage stage sits behind the chain. It is a level-sensitive latch that is transparent while the store strobe is high and holds its value while the strobe is low. The storage stage drives a parallel bus through tri-state drivers, and an output enable controls those drivers.

Two serial taps let several instances be chained into a longer converter. The first tap updates on the rising edge and carries the bit that has just entered the last stage. The second tap copies the first on the following falling edge, which gives the next instance a full half period of hold margin. The strobe and the enable only act on the storage and output side. Shifting and both taps run the same way whatever their levels.

An active-low reset clears the block asynchronously. Its release is synchronised to the shift clock, so the chain starts to shift only on the rising edge that follows the synchroniser depth.

Top module: `ssr_shift_store`

## Requirements
- R1: While rst_n is low, every shift stage, the storage stage, casc_rise and casc_fall are 0. This takes effect without a clock edge, so par_out reads 0 when oe is high.
- R2: On each rising clock edge after reset release, stage 0 takes ser_in and stage n takes the value stage n-1 held before the edge. Stage 0 maps to par_out bit 0 and the last stage maps to bit W-1.
- R3: After each rising edge, casc_rise equals the bit that the edge moved into the last stage (stage W-1).
- R4: On each falling edge, casc_fall takes the value casc_rise holds at that moment. Between falling edges it is constant.
- R5: While strobe is high, the storage stage follows the shift stages, including changes made by rising edges during the high phase.
- R6: While strobe is low, the storage stage keeps its value even though shifting goes on.
- R7: With oe high, par_out drives the storage stage. With oe low, all W bits of par_out are high-impedance.
- R8: oe has no effect on the shift stages, the storage stage or the taps. Contents loaded while oe was low appear unchanged once oe goes high.
- R9: Shifting, casc_rise and casc_fall do not depend on strobe or oe.
- R10: After rst_n rises, the first SYNC_STAGES rising edges shift nothing. The edge numbered SYNC_STAGES+1 (the third edge by default) is the first to capture ser_in.
- R11: When two instances are chained, with the casc_fall of the first feeding ser_in of the second, they act as one 2W-stage register. The second instance holds the older W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge updates casc_fall |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised to clk |
| ser_in | input | 1 | Serial data input into stage 0 |
| strobe | input | 1 | Storage latch enable, transparent while high |
| oe | input | 1 | Parallel output enable; low gives high-impedance |
| par_out | output | W | Tri-state parallel output of the storage stage |
| casc_rise | output | 1 | Cascade tap updated on the rising edge |
| casc_fall | output | 1 | Cascade tap updated on the falling edge |

## Verification
The hardest case to reach from the ports is a storage value that must survive many shifts while the strobe is low and the drivers are off, and then appear intact when the enable returns. The random phase mostly keeps the strobe low and turns oe off about a third of the time, so long runs of hidden shifting occur. A directed sequence also loads a known pattern while oe is low and only then enables the bus. The synchronised reset release and a mid-run asynchronous reset are both driven on purpose, and a second instance chained on the falling-edge tap checks the full 2W-bit conversion against a model.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  parameter int unsigned SSR_DEF_WIDTH = 8;
  parameter int unsigned SSR_DEF_SYNC  = 2;
  typedef enum logic {DRV_OFF = 1'b0, DRV_ON = 1'b1} drv_e;
endpackage

// File: rtl/ssr_rst_sync.sv
`timescale 1ns/1ps
module ssr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  localparam int unsigned LAST = STAGES - 1;
  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[LAST];
endmodule

// File: rtl/ssr_shift_chain.sv
`timescale 1ns/1ps
module ssr_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  output logic [W-1:0] stage_q
);
  logic [W-1:0] stage_d;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb stage_d[i] = ser_in;
      end else begin : g_body
        always_comb stage_d[i] = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_d[i];
      end
    end
  endgenerate
endmodule

// File: rtl/ssr_store_latch.sv
`timescale 1ns/1ps
module ssr_store_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)      q <= '0;
    else if (strobe) q <= d;
  end
endmodule

// File: rtl/ssr_cascade_tap.sv
`timescale 1ns/1ps
module ssr_cascade_tap (
  input  logic clk,
  input  logic rst_n,
  input  logic feed,
  output logic rise_q,
  output logic fall_q
);
  logic rise_d;
  logic fall_d;

  always_comb begin
    rise_d = feed;
    fall_d = rise_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= fall_d;
  end
endmodule

// File: rtl/ssr_shift_store.sv
`timescale 1ns/1ps
module ssr_shift_store
  import ssr_pkg::*;
#(
  parameter int unsigned W           = SSR_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = SSR_DEF_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         strobe,
  input  logic         oe,
  output logic [W-1:0] par_out,
  output logic         casc_rise,
  output logic         casc_fall
);
  localparam int unsigned FEED_IDX = (W > 1) ? W - 2 : 0;

  logic         rst_sync_n;
  logic [W-1:0] stage_q;
  logic [W-1:0] store_q;
  logic         tap_feed;
  drv_e         drv;

  ssr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_q_n(rst_sync_n)
  );

  ssr_shift_chain #(.W(W)) u_chain (
    .clk(clk), .rst_n(rst_sync_n), .ser_in(ser_in), .stage_q(stage_q)
  );

  ssr_store_latch #(.W(W)) u_store (
    .rst_n(rst_sync_n), .strobe(strobe), .d(stage_q), .q(store_q)
  );

  generate
    if (W > 1) begin : g_feed_wide
      always_comb tap_feed = stage_q[FEED_IDX];
    end else begin : g_feed_single
      always_comb tap_feed = ser_in;
    end
  endgenerate

  ssr_cascade_tap u_tap (
    .clk(clk), .rst_n(rst_sync_n), .feed(tap_feed),
    .rise_q(casc_rise), .fall_q(casc_fall)
  );

  always_comb drv = oe ? DRV_ON : DRV_OFF;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_drv
      assign par_out[b] = (drv == DRV_ON) ? store_q[b] : 1'bz;
    end
  endgenerate
endmodule

// File: rtl/ssr_shift_store_chk.sv
`timescale 1ns/1ps
module ssr_shift_store_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_int,
  input logic         ser_in,
  input logic         strobe,
  input logic         oe,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] store_q,
  input logic [W-1:0] par_out,
  input logic         casc_rise,
  input logic         casc_fall
);
  a_r2_shift_head: assert property (@(posedge clk) disable iff (!rst_int)
    $past(rst_int) |-> shift_q[0] == $past(ser_in));

  a_r2_shift_body: assert property (@(posedge clk) disable iff (!rst_int)
    $past(rst_int) |-> shift_q[W-1:1] == $past(shift_q[W-2:0]));

  a_r3_rise_tap: assert property (@(posedge clk) disable iff (!rst_int)
    $past(rst_int) |-> casc_rise == shift_q[W-1]);

  a_r4_fall_tap: assert property (@(posedge clk) disable iff (!rst_int)
    casc_fall == casc_rise);

  a_r5_store_follows: assert property (@(posedge clk) disable iff (!rst_int)
    strobe |-> store_q == shift_q);

  a_r6_store_holds: assert property (@(posedge clk) disable iff (!rst_int)
    (!strobe && $past(!strobe)) |-> $stable(store_q));

  a_r7_bus_drive: assert property (@(posedge clk) disable iff (!rst_int)
    oe |-> par_out == store_q);
endmodule

bind ssr_shift_store ssr_shift_store_chk #(.W(W)) u_chk (
  .clk(clk), .rst_int(rst_sync_n), .ser_in(ser_in), .strobe(strobe),
  .oe(oe), .shift_q(stage_q), .store_q(store_q), .par_out(par_out),
  .casc_rise(casc_rise), .casc_fall(casc_fall)
);

// File: tb/sim_ssr_shift_store.sv
`timescale 1ns/1ps
module sim_ssr_shift_store;
  localparam int W    = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n, ser_in, strobe, oe;
  logic [W-1:0] par0, par1;
  logic rise0, fall0, rise1, fall1;

  always #5 clk = ~clk;

  ssr_shift_store #(.W(W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .oe(oe),
    .par_out(par0), .casc_rise(rise0), .casc_fall(fall0));

  ssr_shift_store #(.W(W), .SYNC_STAGES(SYNC)) u1 (
    .clk(clk), .rst_n(rst_n), .ser_in(fall0), .strobe(strobe), .oe(oe),
    .par_out(par1), .casc_rise(rise1), .casc_fall(fall1));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2*W-1:0] chain_m;
  logic [W-1:0] st0_m, st1_m;
  logic r0_m, f0_m, r1_m, f1_m;
  int rel;

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_bus(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input logic en);
    bit ok;
    checks++;
    if (en) ok = (act === exp);
    else    ok = (act === {W{1'bz}}) || (act === {W{1'b0}});
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h oe=%b at %0t", tag, act, exp, en, $time);
    end
  endtask

  function automatic logic [2*W-1:0] shift_model(input logic [2*W-1:0] c, input logic d);
    return {c[2*W-2:0], d};
  endfunction

  task automatic model_clear();
    chain_m = '0; st0_m = '0; st1_m = '0;
    r0_m = 0; f0_m = 0; r1_m = 0; f1_m = 0; rel = 0;
  endtask

  // One clock period: drive after a falling edge, check after the next one.
  task automatic cycle(input logic d, input logic s, input logic o, input string tag);
    ser_in = d; strobe = s; oe = o;
    if (s) begin st0_m = chain_m[W-1:0]; st1_m = chain_m[2*W-1:W]; end
    @(posedge clk);
    if (rel < SYNC) rel++;
    else begin
      chain_m = shift_model(chain_m, d);
      r0_m = chain_m[W-1];
      r1_m = chain_m[2*W-1];
    end
    if (s) begin st0_m = chain_m[W-1:0]; st1_m = chain_m[2*W-1:W]; end
    @(negedge clk);
    f0_m = r0_m; f1_m = r1_m;
    #1;
    chk1({tag, " R3 rise0"}, rise0, r0_m);
    chk1({tag, " R4 fall0"}, fall0, f0_m);
    chk1({tag, " R3 rise1"}, rise1, r1_m);
    chk1({tag, " R4 fall1"}, fall1, f1_m);
    chk_bus({tag, " R7 par0"}, par0, st0_m, o);
    chk_bus({tag, " R11 par1"}, par1, st1_m, o);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] pat;
    void'($urandom(32'd4094));
    rst_n = 0; ser_in = 0; strobe = 1; oe = 1;
    model_clear();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk_bus("R1 reset par0", par0, '0, 1'b1);
    chk1("R1 reset rise0", rise0, 1'b0);
    chk1("R1 reset fall0", fall0, 1'b0);

    // R10: release is synchronised; edge SYNC+1 is the first to shift
    rst_n = 1;
    for (int k = 0; k < SYNC; k++) cycle(1'b1, 1'b1, 1'b1, "R10 idle");
    chk_bus("R10 no shift yet", par0, '0, 1'b1);
    cycle(1'b1, 1'b1, 1'b1, "R10 first");
    chk_bus("R10 first capture", par0, 8'h01, 1'b1);

    // R2/R5: shift a known byte with strobe high
    for (int k = W-1; k >= 0; k--) cycle(pat_bit(8'hA5, k), 1'b1, 1'b1, "R2 load");
    chk_bus("R2 R5 byte A5", par0, 8'hA5, 1'b1);

    // R6: strobe low, shifting continues, bus keeps A5
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0, 1'b1, "R6 hold");
    chk_bus("R6 held A5", par0, 8'hA5, 1'b1);

    // R8: load 3C while drivers are off, then enable with strobe low
    for (int k = W-1; k >= 0; k--) cycle(pat_bit(8'h3C, k), 1'b1, 1'b0, "R8 hidden");
    cycle(1'b1, 1'b0, 1'b1, "R8 reveal");
    chk_bus("R8 contents kept", par0, 8'h3C, 1'b1);

    // R11: 16-bit conversion through the falling-edge tap
    pat = 16'hC35A;
    for (int k = 2*W-1; k >= 0; k--) cycle(pat[k], 1'b0, 1'b1, "R11 stream");
    cycle(1'b0, 1'b1, 1'b1, "R11 store");
    chk_bus("R11 high byte", par1, 8'h86, 1'b1);
    chk_bus("R11 low byte", par0, 8'hB4, 1'b1);

    // R9: random mix of strobe/oe, shifting and taps must not care
    for (int k = 0; k < 600; k++)
      cycle(logic'($urandom % 2), logic'(($urandom % 4) == 0),
            logic'(($urandom % 3) != 0), "R9 random");

    // R1: asynchronous reset mid-run, no clock edge needed
    oe = 1; strobe = 0;
    rst_n = 0;
    #1;
    chk_bus("R1 async par0", par0, '0, 1'b1);
    chk_bus("R1 async par1", par1, '0, 1'b1);
    chk1("R1 async rise1", rise1, 1'b0);
    chk1("R1 async fall0", fall0, 1'b0);
    model_clear();
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 20; k++) cycle(1'b1, 1'b1, 1'b1, "R10 restart");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic pat_bit(input logic [W-1:0] v, input int k);
    return v[k];
  endfunction
endmodule